// File: doc/BRIEF.md
# Home-Node Directory Snoop Controller

This block keeps a coherence directory at the home node for a small set of request nodes (four by default) and a small set of tracked lines. Each directory entry records a line state (invalid, unique clean, unique dirty or shared), a holder bit vector with one bit per request node, and a separate dirty-owner field that is valid only while a shared line is still modified with respect to main memory. The protocol is write-invalidate.

A request names an operation, a requesting node and a line. In the same cycle the controller reads the entry and decides where data comes from: main memory when no cache holds the line, or a cached copy otherwise. It selects one forwarding holder, chooses the forwarding snoop type, marks every other holder for invalidation when the request asks for a unique copy, works out the state the requester is granted, and writes the updated entry back. The decision appears on registered outputs one cycle after the request. Two write operations let a holder give up dirty responsibility: one keeps the copy and one drops it. Data movement, memory timing and retries are handled elsewhere.

Top module: `hn_dir_ctrl`

## Requirements
- R1: After reset every entry is invalid with no holders, and rsp_valid, mem_rd, snp_fwd_op (0), snp_fwd_tgt (0), snp_inv_mask and rsp_grant (0) are all zero.
- R2: A request accepted with req_valid high produces rsp_valid in the next cycle. Opcodes: 0 read-shared, 1 read-unique, 2 write-back-full, 3 write-clean-full. A read to a line with no holders raises mem_rd with no snoop; read-unique grants unique clean (grant code 3) and read-shared grants shared clean (grant code 1). Grant codes: 0 invalid, 1 shared clean, 2 shared dirty, 3 unique clean, 4 unique dirty.
- R3: mem_rd is raised only when the holder vector was empty at request time, and never together with any snoop.
- R4: A read-shared from a non-holder to a held line sends a shared forwarding snoop (snp_fwd_op 1) to the lowest-numbered holder on snp_fwd_tgt, invalidates nobody, and adds the requester as a holder; the grant is shared dirty if the line was unique dirty or had a dirty owner, else shared clean.
- R5: When that read-shared hits a dirty line, dirty ownership moves to the requester and every earlier holder stays a shared-clean holder, so a later read-shared still grants shared dirty until the current owner writes back.
- R6: A read-unique while any other node holds the line sends a unique forwarding snoop (snp_fwd_op 2) to the lowest-numbered other holder, sets snp_inv_mask for every remaining other holder, grants unique dirty, and leaves only the requester recorded.
- R7: A read-shared from a node that already holds the line causes no snoop and no memory read and grants its current state unchanged; a read-unique from the sole holder grants unique dirty if the line is dirty, else unique clean, without snoops.
- R8: Write-back-full from a holder removes it and clears any ownership it had, grants invalid, and an entry left with no holders returns to invalid, so the next read goes to memory.
- R9: Write-clean-full from a holder keeps it as a holder, clears ownership if it was the owner, and grants shared clean; a unique line becomes shared.
- R10: A write from a node that does not hold the line leaves the entry unchanged and grants invalid with no snoop and no memory read.
- R11: Writes never issue snoops or memory reads, and entries of different lines are independent.
- R12: In a cycle after one with req_valid low, rsp_valid and all decision outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request opcode |
| req_node | input | $clog2(NUM_RN) | Requesting node index |
| req_line | input | $clog2(NUM_LINES) | Directory line index |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 3 | State granted to the requester |
| snp_fwd_op | output | 2 | Forwarding snoop type: 0 none, 1 shared, 2 unique |
| snp_fwd_tgt | output | $clog2(NUM_RN) | Node receiving the forwarding snoop |
| snp_inv_mask | output | NUM_RN | Nodes receiving an invalidating snoop |
| mem_rd | output | 1 | Read the line from main memory |

## Verification
The checker holds on every cycle the structural rules of a decision: memory reads never coincide with snoops, invalidations only accompany a unique forward and never hit the forwarder or requester, a unique forward always grants unique dirty, writes stay quiet and idle cycles produce no decision. Whether the right holder was picked, whether dirty ownership travelled to the newest reader, and whether an entry correctly returned to invalid depend on history across many requests, so only the bench's directed chains and its randomly ordered request stream, compared against its own directory model, can show them.

// File: rtl/hn_dir_pkg.sv
package hn_dir_pkg;

    typedef enum logic [1:0] {
        LS_I  = 2'd0,
        LS_UC = 2'd1,
        LS_UD = 2'd2,
        LS_SH = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD_SHR = 2'd0,
        OP_RD_UNQ = 2'd1,
        OP_WB_FUL = 2'd2,
        OP_WC_FUL = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        GR_I  = 3'd0,
        GR_SC = 3'd1,
        GR_SD = 3'd2,
        GR_UC = 3'd3,
        GR_UD = 3'd4
    } grant_e;

    typedef enum logic [1:0] {
        SF_NONE   = 2'd0,
        SF_SHARED = 2'd1,
        SF_UNIQUE = 2'd2
    } fwd_op_e;

    function automatic logic is_write(input req_op_e op);
        return (op == OP_WB_FUL) || (op == OP_WC_FUL);
    endfunction

endpackage

// File: rtl/hn_dir_lowbit.sv
module hn_dir_lowbit #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/hn_dir_store.sv
module hn_dir_store
    import hn_dir_pkg::*;
#(
    parameter int NUM_RN    = 4,
    parameter int NUM_LINES = 8,
    localparam int NODE_W = (NUM_RN > 1) ? $clog2(NUM_RN) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_line,
    output line_st_e          rd_st,
    output logic [NUM_RN-1:0] rd_shr,
    output logic              rd_ov,
    output logic [NODE_W-1:0] rd_own,
    input  logic              wr_en,
    input  line_st_e          wr_st,
    input  logic [NUM_RN-1:0] wr_shr,
    input  logic              wr_ov,
    input  logic [NODE_W-1:0] wr_own
);
    line_st_e          st_q  [NUM_LINES];
    logic [NUM_RN-1:0] shr_q [NUM_LINES];
    logic              ov_q  [NUM_LINES];
    logic [NODE_W-1:0] own_q [NUM_LINES];

    assign rd_st  = st_q[rd_line];
    assign rd_shr = shr_q[rd_line];
    assign rd_ov  = ov_q[rd_line];
    assign rd_own = own_q[rd_line];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= LS_I;
                shr_q[i] <= '0;
                ov_q[i]  <= 1'b0;
                own_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[rd_line]  <= wr_st;
            shr_q[rd_line] <= wr_shr;
            ov_q[rd_line]  <= wr_ov;
            own_q[rd_line] <= wr_own;
        end
    end
endmodule

// File: rtl/hn_dir_next.sv
module hn_dir_next
    import hn_dir_pkg::*;
#(
    parameter int NUM_RN = 4,
    localparam int NODE_W = (NUM_RN > 1) ? $clog2(NUM_RN) : 1
) (
    input  req_op_e           op,
    input  logic [NODE_W-1:0] node,
    input  line_st_e          cur_st,
    input  logic [NUM_RN-1:0] cur_shr,
    input  logic              cur_ov,
    input  logic [NODE_W-1:0] cur_own,
    output line_st_e          nxt_st,
    output logic [NUM_RN-1:0] nxt_shr,
    output logic              nxt_ov,
    output logic [NODE_W-1:0] nxt_own,
    output grant_e            grant,
    output fwd_op_e           fop,
    output logic [NODE_W-1:0] ftgt,
    output logic [NUM_RN-1:0] inv,
    output logic              mem
);
    logic [NUM_RN-1:0] req_bit;
    logic [NUM_RN-1:0] others;
    logic [NUM_RN-1:0] tgt_bit;
    logic              holding;
    logic              dirty;
    logic              own_me;
    logic              any_other;
    logic [NODE_W-1:0] low_idx;
    grant_e            cur_grant;

    assign req_bit = NUM_RN'(1) << node;
    assign others  = cur_shr & ~req_bit;
    assign holding = |(cur_shr & req_bit);
    assign dirty   = (cur_st == LS_UD) || cur_ov;
    assign own_me  = cur_ov && (cur_own == node);
    assign tgt_bit = NUM_RN'(1) << low_idx;

    hn_dir_lowbit #(.N(NUM_RN)) pick_i (
        .vec (others),
        .any (any_other),
        .idx (low_idx)
    );

    always_comb begin
        unique case (cur_st)
            LS_UC:   cur_grant = GR_UC;
            LS_UD:   cur_grant = GR_UD;
            LS_SH:   cur_grant = own_me ? GR_SD : GR_SC;
            default: cur_grant = GR_I;
        endcase
    end

    always_comb begin
        nxt_st  = cur_st;
        nxt_shr = cur_shr;
        nxt_ov  = cur_ov;
        nxt_own = cur_own;
        grant   = GR_I;
        fop     = SF_NONE;
        ftgt    = low_idx;
        inv     = '0;
        mem     = 1'b0;
        unique case (op)
            OP_RD_SHR: begin
                if (cur_shr == '0) begin
                    mem     = 1'b1;
                    grant   = GR_SC;
                    nxt_st  = LS_SH;
                    nxt_shr = req_bit;
                    nxt_ov  = 1'b0;
                end else if (holding) begin
                    grant = cur_grant;
                end else begin
                    fop     = SF_SHARED;
                    grant   = dirty ? GR_SD : GR_SC;
                    nxt_st  = LS_SH;
                    nxt_shr = cur_shr | req_bit;
                    nxt_ov  = dirty;
                    nxt_own = dirty ? node : cur_own;
                end
            end
            OP_RD_UNQ: begin
                nxt_shr = req_bit;
                nxt_ov  = 1'b0;
                if (cur_shr == '0) begin
                    mem    = 1'b1;
                    grant  = GR_UC;
                    nxt_st = LS_UC;
                end else if (!any_other) begin
                    grant  = dirty ? GR_UD : GR_UC;
                    nxt_st = dirty ? LS_UD : LS_UC;
                end else begin
                    fop    = SF_UNIQUE;
                    inv    = others & ~tgt_bit;
                    grant  = GR_UD;
                    nxt_st = LS_UD;
                end
            end
            OP_WB_FUL: begin
                if (holding) begin
                    nxt_shr = cur_shr & ~req_bit;
                    if (own_me) nxt_ov = 1'b0;
                    if ((cur_shr & ~req_bit) == '0) begin
                        nxt_st = LS_I;
                        nxt_ov = 1'b0;
                    end else begin
                        nxt_st = LS_SH;
                    end
                end
            end
            default: begin
                if (holding) begin
                    grant  = GR_SC;
                    nxt_st = LS_SH;
                    if (own_me) nxt_ov = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/hn_dir_ctrl.sv
module hn_dir_ctrl
    import hn_dir_pkg::*;
#(
    parameter int NUM_RN    = 4,
    parameter int NUM_LINES = 8,
    localparam int NODE_W = (NUM_RN > 1) ? $clog2(NUM_RN) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    output logic              rsp_valid,
    output logic [2:0]        rsp_grant,
    output logic [1:0]        snp_fwd_op,
    output logic [NODE_W-1:0] snp_fwd_tgt,
    output logic [NUM_RN-1:0] snp_inv_mask,
    output logic              mem_rd
);
    line_st_e          cur_st,  nxt_st;
    logic [NUM_RN-1:0] cur_shr, nxt_shr;
    logic              cur_ov,  nxt_ov;
    logic [NODE_W-1:0] cur_own, nxt_own;
    grant_e            grant;
    fwd_op_e           fop;
    logic [NODE_W-1:0] ftgt;
    logic [NUM_RN-1:0] inv;
    logic              mem;

    hn_dir_store #(.NUM_RN(NUM_RN), .NUM_LINES(NUM_LINES)) store_i (
        .clk     (clk),
        .rst     (rst),
        .rd_line (req_line),
        .rd_st   (cur_st),
        .rd_shr  (cur_shr),
        .rd_ov   (cur_ov),
        .rd_own  (cur_own),
        .wr_en   (req_valid),
        .wr_st   (nxt_st),
        .wr_shr  (nxt_shr),
        .wr_ov   (nxt_ov),
        .wr_own  (nxt_own)
    );

    hn_dir_next #(.NUM_RN(NUM_RN)) next_i (
        .op      (req_op_e'(req_op)),
        .node    (req_node),
        .cur_st  (cur_st),
        .cur_shr (cur_shr),
        .cur_ov  (cur_ov),
        .cur_own (cur_own),
        .nxt_st  (nxt_st),
        .nxt_shr (nxt_shr),
        .nxt_ov  (nxt_ov),
        .nxt_own (nxt_own),
        .grant   (grant),
        .fop     (fop),
        .ftgt    (ftgt),
        .inv     (inv),
        .mem     (mem)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid    <= 1'b0;
            rsp_grant    <= '0;
            snp_fwd_op   <= '0;
            snp_fwd_tgt  <= '0;
            snp_inv_mask <= '0;
            mem_rd       <= 1'b0;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_grant    <= grant;
            snp_fwd_op   <= fop;
            snp_fwd_tgt  <= (fop != SF_NONE) ? ftgt : '0;
            snp_inv_mask <= inv;
            mem_rd       <= mem;
        end
    end
endmodule

// File: rtl/hn_dir_chk.sv
module hn_dir_chk #(
    parameter int NUM_RN    = 4,
    parameter int NUM_LINES = 8,
    localparam int NODE_W = (NUM_RN > 1) ? $clog2(NUM_RN) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [NODE_W-1:0] req_node,
    input logic [LINE_W-1:0] req_line,
    input logic              rsp_valid,
    input logic [2:0]        rsp_grant,
    input logic [1:0]        snp_fwd_op,
    input logic [NODE_W-1:0] snp_fwd_tgt,
    input logic [NUM_RN-1:0] snp_inv_mask,
    input logic              mem_rd
);
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !mem_rd && snp_fwd_op == 2'd0 && snp_inv_mask == '0));

    p_mem_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (snp_fwd_op == 2'd0 && snp_inv_mask == '0));

    p_mem_grant_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (rsp_grant == 3'd1 || rsp_grant == 3'd3));

    p_inv_needs_unique_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_inv_mask != '0) |-> (snp_fwd_op == 2'd2));

    p_fwd_not_inv_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_fwd_op != 2'd0) |-> !snp_inv_mask[snp_fwd_tgt]);

    p_unique_grant_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_fwd_op == 2'd2) |-> (rsp_grant == 3'd4));

    p_no_self_snoop_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1] == 1'b0) |=>
            ((snp_fwd_op == 2'd0 || snp_fwd_tgt != $past(req_node)) &&
             !snp_inv_mask[$past(req_node)]));

    p_write_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1]) |=>
            (!mem_rd && snp_fwd_op == 2'd0 && snp_inv_mask == '0 &&
             (rsp_grant == 3'd0 || rsp_grant == 3'd1)));

    p_one_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        snp_fwd_op != 2'd3);
endmodule

bind hn_dir_ctrl hn_dir_chk #(.NUM_RN(NUM_RN), .NUM_LINES(NUM_LINES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_node     (req_node),
    .req_line     (req_line),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .snp_fwd_op   (snp_fwd_op),
    .snp_fwd_tgt  (snp_fwd_tgt),
    .snp_inv_mask (snp_inv_mask),
    .mem_rd       (mem_rd)
);

// File: tb/hn_dir_ctrl_tb_top.sv
module hn_dir_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRN   = 4;
    localparam int NLN   = 8;
    localparam int NW    = 2;
    localparam int LW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [NW-1:0] req_node = '0;
    logic [LW-1:0] req_line = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_grant;
    logic [1:0]    snp_fwd_op;
    logic [NW-1:0] snp_fwd_tgt;
    logic [NRN-1:0] snp_inv_mask;
    logic          mem_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: 0 I, 1 UC, 2 UD, 3 SH
    int       m_st  [NLN];
    bit [3:0] m_shr [NLN];
    bit       m_ov  [NLN];
    int       m_own [NLN];

    always #(CLK_PERIOD/2) clk = ~clk;

    hn_dir_ctrl #(.NUM_RN(NRN), .NUM_LINES(NLN)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_node(req_node), .req_line(req_line), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .snp_fwd_op(snp_fwd_op), .snp_fwd_tgt(snp_fwd_tgt),
        .snp_inv_mask(snp_inv_mask), .mem_rd(mem_rd)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input int op, input int node, input int ln,
                         output int g, output int f, output int t,
                         output int inv, output int mem, output string tag);
        bit [3:0] rb, shr, oth;
        bit hold, dirty, ownme;
        int low;
        rb = 4'(1 << node);
        shr = m_shr[ln];
        oth = shr & ~rb;
        hold = (shr & rb) != 0;
        dirty = (m_st[ln] == 2) || m_ov[ln];
        ownme = m_ov[ln] && (m_own[ln] == node);
        low = 0;
        for (int i = NRN - 1; i >= 0; i--) if (oth[i]) low = i;
        g = 0; f = 0; t = 0; inv = 0; mem = 0; tag = "R10";
        if (op == 0) begin
            if (shr == 0) begin
                mem = 1; g = 1; tag = "R2";
                m_st[ln] = 3; m_shr[ln] = rb; m_ov[ln] = 0;
            end else if (hold) begin
                tag = "R7";
                g = (m_st[ln] == 1) ? 3 : (m_st[ln] == 2) ? 4 : (ownme ? 2 : 1);
            end else begin
                tag = dirty ? "R5" : "R4";
                f = 1; t = low; g = dirty ? 2 : 1;
                m_st[ln] = 3; m_shr[ln] = shr | rb; m_ov[ln] = dirty;
                if (dirty) m_own[ln] = node;
            end
        end else if (op == 1) begin
            if (shr == 0) begin
                mem = 1; g = 3; m_st[ln] = 1; tag = "R2";
            end else if (oth == 0) begin
                g = dirty ? 4 : 3; m_st[ln] = dirty ? 2 : 1; tag = "R7";
            end else begin
                f = 2; t = low; inv = int'(oth & ~4'(1 << low)); g = 4;
                m_st[ln] = 2; tag = "R6";
            end
            m_shr[ln] = rb; m_ov[ln] = 0;
        end else if (op == 2) begin
            if (hold) begin
                tag = "R8";
                m_shr[ln] = shr & ~rb;
                if (ownme) m_ov[ln] = 0;
                if (m_shr[ln] == 0) begin m_st[ln] = 0; m_ov[ln] = 0; end
                else m_st[ln] = 3;
            end
        end else begin
            if (hold) begin
                tag = "R9"; g = 1; m_st[ln] = 3;
                if (ownme) m_ov[ln] = 0;
            end
        end
    endtask

    // drive at negedge, sample the registered decision at the next negedge
    task automatic req(input int op, input int node, input int ln);
        int g, f, t, inv, mem;
        string tag;
        model(op, node, ln, g, f, t, inv, mem, tag);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_node  = NW'(node);
        req_line  = LW'(ln);
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, int'(rsp_valid), 1, "rsp_valid R2");
        chk(tag, int'(rsp_grant), g, "grant");
        chk(tag, int'(snp_fwd_op), f, "fwd_op");
        chk(tag, int'(snp_fwd_tgt), t, "fwd_tgt");
        chk(tag, int'(snp_inv_mask), inv, "inv_mask");
        chk(op >= 2 ? "R11" : "R3", int'(mem_rd), mem, "mem_rd");
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R12", int'(rsp_valid), 0, "rsp_valid idle");
        chk("R12", int'({snp_fwd_op, snp_inv_mask, mem_rd, rsp_grant}), 0, "outputs idle");
    endtask

    initial begin
        for (int i = 0; i < NLN; i++) begin
            m_st[i] = 0; m_shr[i] = 0; m_ov[i] = 0; m_own[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'({rsp_valid, mem_rd, snp_fwd_op, snp_fwd_tgt, snp_inv_mask, rsp_grant}), 0, "reset outputs");

        // R2, R4: unique clean then shared by second node
        req(1, 0, 0);
        req(0, 1, 0);
        idle_check();
        // R7: re-request by holder
        req(1, 0, 1);
        req(0, 0, 1);
        req(1, 0, 1);
        // R6, R5: dirty chain on line 2
        req(0, 0, 2);
        req(1, 1, 2);
        req(0, 2, 2);
        req(0, 3, 2);
        req(3, 3, 2);   // R9 owner writes clean
        req(0, 0, 2);   // now clean share
        req(1, 0, 2);   // R6 upgrade with three other holders
        req(2, 0, 2);   // R8 last holder leaves
        req(0, 2, 2);   // memory again
        req(2, 1, 2);   // R10 non-holder write
        req(0, 3, 2);
        // R8: owner write-back keeps line shared; R11 line independence
        req(1, 3, 3);
        req(1, 2, 3);
        req(0, 1, 3);
        req(2, 1, 3);
        req(0, 0, 3);
        req(0, 0, 4);   // untouched line still goes to memory (R11)
        idle_check();

        // random mix against the model
        void'($urandom(32'h1CE5EED));
        for (int n = 0; n < 600; n++) begin
            req(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) idle_check();
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule